// File: doc/BRIEF.md
# Command-Line CRC7 Generator and Checker

This block computes a 7-bit cyclic redundancy code over a serial bit stream on a card command line. The host feeds it one protected bit per valid strobe, most significant bit first. When the programmed number of bits has been absorbed, the block reports completion. If checking is enabled, it also compares the finished remainder with a received 7-bit code. The same remainder can then be drained out one bit at a time, highest bit first, and appended to an outgoing command.

Two frame lengths are supported. The short length covers 40 bits and is used for commands and responses. The long length covers 120 bits and is used for the contents of the card identification and card-specific registers. For the one response type that carries no code, checking is turned off with a check-enable input.

A small controller sequences the work through three named states. ST_ACCUM absorbs bits and counts them. ST_HOLD keeps the finished remainder and ignores further data bits. ST_SHIFT drains the remainder. The transitions are:
- ACCUM_TO_HOLD happens on the last protected bit.
- HOLD_TO_SHIFT happens on the first drain strobe.
- SHIFT_TO_ACCUM happens on the seventh drain strobe.
- ANY_TO_ACCUM happens on a clear.

Top module: `cmdline_crc7`

## Requirements
- R1: The remainder uses the generator x^7 + x^3 + 1, starts at zero, and takes bits leftmost first. A 40-bit string of 0x40 followed by 32 zero bits must leave the remainder 0x4A.
- R2: After reset, and in the cycle after a clear, the remainder, the bit count, done and mismatch are all zero. A clear wins over a valid bit presented in the same cycle.
- R3: With long_mode_i = 0, the string ends at the 40th valid bit, and rem_o then equals the CRC7 of those 40 bits.
- R4: With long_mode_i = 1, the string ends at the 120th valid bit, and rem_o then equals the CRC7 of those 120 bits.
- R5: done_o is high for exactly one cycle. That cycle is the one that follows the clock edge that absorbed the final bit. done_o is low after every earlier bit.
- R6: When chk_en_i is 1 at the final bit, mismatch_o is high together with done_o exactly when the finished remainder differs from rx_crc_i as sampled at that edge.
- R7: When chk_en_i is 0 at the final bit, mismatch_o stays low whatever the value of rx_crc_i.
- R8: Cycles with bit_vld_i low do not change the remainder. Valid bits presented in ST_HOLD do not change it either.
- R9: tx_bit_o always shows remainder bit 6. Each sh_en_i in ST_HOLD or ST_SHIFT shifts the remainder left and fills bit 0 with zero. After 7 such strobes the block is back in ST_ACCUM with a zero remainder and a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of remainder, counters and state |
| bit_vld_i | input | 1 | The data bit on bit_i is valid this cycle |
| bit_i | input | 1 | Serial protected bit, leftmost first |
| long_mode_i | input | 1 | 0 selects a 40-bit string, 1 selects a 120-bit string; hold it stable during a string |
| chk_en_i | input | 1 | Enables the comparison at the end of a string |
| rx_crc_i | input | 7 | Received code to compare against |
| sh_en_i | input | 1 | Drain strobe: shifts the finished remainder out |
| rem_o | output | 7 | Running remainder |
| tx_bit_o | output | 1 | Remainder bit 6, the next bit to transmit |
| done_o | output | 1 | One-cycle pulse after the final bit |
| mismatch_o | output | 1 | Compare failure, valid with done_o |

## Verification
The effects of any input appear one clock edge later. rem_o, done_o and mismatch_o all reflect the bit presented before the preceding rising edge. tx_bit_o follows rem_o with no further delay. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each result is checked exactly one edge after its stimulus. The bench also checks the cycle after done_o to confirm that the pulse has ended. Expected codes come from a polynomial long division in the bench: the message is padded with seven zeros and divided. This differs in form from the shift-register update used by the design.

// File: rtl/crc7_cmd_pkg.sv
package crc7_cmd_pkg;

    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SHIFT = 2'd2
    } crc_state_e;

    typedef enum logic [1:0] {
        OP_KEEP  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_FEED  = 2'd2,
        OP_DRAIN = 2'd3
    } crc_op_e;

endpackage

// File: rtl/crc7_lfsr.sv
module crc7_lfsr
    import crc7_cmd_pkg::*;
#(
    parameter int               W    = 7,
    parameter logic [W-1:0]     POLY = 7'h09
) (
    input  logic          clk,
    input  logic          rst_n,
    input  crc_op_e       op,
    input  logic          din,
    output logic [W-1:0]  crc_q,
    output logic [W-1:0]  crc_d
);

    logic fb;

    assign fb = din ^ crc_q[W-1];

    always_comb begin
        crc_d = crc_q;
        unique case (op)
            OP_KEEP:  crc_d = crc_q;
            OP_CLEAR: crc_d = '0;
            OP_FEED:  crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
            OP_DRAIN: crc_d = {crc_q[W-2:0], 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    // R2: a clear leaves a zero remainder
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (crc_q == '0));

    // R9: draining fills the low bit with zero
    p_drain_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DRAIN) |=> (crc_q[0] == 1'b0));

endmodule

// File: rtl/crc7_ctrl.sv
module crc7_ctrl
    import crc7_cmd_pkg::*;
#(
    parameter int W         = 7,
    parameter int SHORT_LEN = 40,
    parameter int LONG_LEN  = 120
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        vld,
    input  logic        long_mode,
    input  logic        sh_en,
    output crc_op_e     op,
    output logic        last,
    output crc_state_e  state_o
);

    localparam int CNT_W = $clog2(LONG_LEN + 1);
    localparam int SH_W  = $clog2(W + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
    localparam logic [SH_W-1:0]  SH_LAST    = SH_W'(W - 1);

    crc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SH_W-1:0]  sh_q, sh_d;
    logic [CNT_W-1:0] limit;

    assign limit   = long_mode ? LONG_LAST : SHORT_LAST;
    assign state_o = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACCUM;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        op      = OP_KEEP;
        last    = 1'b0;
        if (clr) begin
            // ANY_TO_ACCUM
            state_d = ST_ACCUM;
            cnt_d   = '0;
            sh_d    = '0;
            op      = OP_CLEAR;
        end else begin
            unique case (state_q)
                ST_ACCUM: begin
                    if (vld) begin
                        op = OP_FEED;
                        if (cnt_q >= limit) begin
                            // ACCUM_TO_HOLD
                            last    = 1'b1;
                            state_d = ST_HOLD;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (sh_en) begin
                        // HOLD_TO_SHIFT
                        op      = OP_DRAIN;
                        state_d = ST_SHIFT;
                        sh_d    = SH_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (sh_en) begin
                        op = OP_DRAIN;
                        if (sh_q == SH_LAST) begin
                            // SHIFT_TO_ACCUM
                            state_d = ST_ACCUM;
                            sh_d    = '0;
                        end else begin
                            sh_d = sh_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_ACCUM;
                    cnt_d   = '0;
                    sh_d    = '0;
                end
            endcase
        end
    end

    // R4: the bit count never passes the longest string
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LONG_LAST);

    // R9: the drain counter is idle outside ST_SHIFT
    p_drain_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |-> (sh_q == '0));

    // R2: a clear returns the sequencer to accumulation with zero count
    p_clear_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_ACCUM && cnt_q == '0));

    // R8: the count only moves in ST_ACCUM
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACCUM) |-> (cnt_q == '0));

endmodule

// File: rtl/cmdline_crc7.sv
module cmdline_crc7
    import crc7_cmd_pkg::*;
#(
    parameter int               CRC_W     = 7,
    parameter logic [CRC_W-1:0] POLY      = 7'h09,
    parameter int               SHORT_LEN = 40,
    parameter int               LONG_LEN  = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    input  logic             long_mode_i,
    input  logic             chk_en_i,
    input  logic [CRC_W-1:0] rx_crc_i,
    input  logic             sh_en_i,
    output logic [CRC_W-1:0] rem_o,
    output logic             tx_bit_o,
    output logic             done_o,
    output logic             mismatch_o
);

    crc_op_e          op;
    logic             last;
    crc_state_e       state;
    logic [CRC_W-1:0] crc_next;
    logic             done_q, mism_q;

    crc7_ctrl #(
        .W         (CRC_W),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_i),
        .vld       (bit_vld_i),
        .long_mode (long_mode_i),
        .sh_en     (sh_en_i),
        .op        (op),
        .last      (last),
        .state_o   (state)
    );

    crc7_lfsr #(
        .W    (CRC_W),
        .POLY (POLY)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .din   (bit_i),
        .crc_q (rem_o),
        .crc_d (crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            mism_q <= 1'b0;
        end else begin
            done_q <= last;
            mism_q <= last && chk_en_i && (crc_next != rx_crc_i);
        end
    end

    assign done_o     = done_q;
    assign mismatch_o = mism_q;
    assign tx_bit_o   = rem_o[CRC_W-1];

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: a mismatch only appears with completion
    p_mism_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> done_o);

    // R6: mismatch reflects the finished remainder against the sampled code
    p_mism_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(chk_en_i)) |-> (mismatch_o == (rem_o != $past(rx_crc_i))));

    // R7: checking disabled never flags
    p_no_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(chk_en_i)) |-> !mismatch_o);

    // R8: held remainder ignores data bits
    p_hold_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !clr_i && !sh_en_i) |=> $stable(rem_o));

endmodule

// File: tb/tb_cmdline_crc7.sv
module tb_cmdline_crc7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       long_mode_i = 1'b0;
    logic       chk_en_i = 1'b0;
    logic [6:0] rx_crc_i = '0;
    logic       sh_en_i = 1'b0;
    logic [6:0] rem_o;
    logic       tx_bit_o, done_o, mismatch_o;

    int vectors = 0;
    int fails = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    cmdline_crc7 dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .long_mode_i(long_mode_i), .chk_en_i(chk_en_i),
        .rx_crc_i(rx_crc_i), .sh_en_i(sh_en_i), .rem_o(rem_o),
        .tx_bit_o(tx_bit_o), .done_o(done_o), .mismatch_o(mismatch_o)
    );

    // long division of message * x^7 by x^7 + x^3 + 1 (0x89)
    function automatic logic [6:0] ref_crc(input logic [119:0] m, input int n);
        logic [126:0] d;
        d = '0;
        d[126:7] = m;
        for (int i = n + 6; i >= 7; i--)
            if (d[i]) d[i-7 +: 8] = d[i-7 +: 8] ^ 8'h89;
        return d[6:0];
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic tick(input logic v, input logic b, input logic s, input logic c);
        bit_vld_i = v; bit_i = b; sh_en_i = s; clr_i = c;
        @(negedge clk);
        bit_vld_i = 1'b0; bit_i = 1'b0; sh_en_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic run_string(input logic lng, input logic [119:0] m,
                              input logic chk, input logic corrupt, input logic gaps);
        int n;
        logic [6:0] exp;
        n = lng ? 120 : 40;
        exp = ref_crc(m, n);
        long_mode_i = lng;
        chk_en_i = chk;
        rx_crc_i = corrupt ? (exp ^ 7'h01) : exp;
        for (int i = n - 1; i >= 0; i--) begin
            if (gaps && (i % 5 == 0)) tick(1'b0, ~m[i], 1'b0, 1'b0); // R8 idle cycle
            tick(1'b1, m[i], 1'b0, 1'b0);
            if (i != 0) check("R5 done early", {31'b0, done_o}, 32'd0);
        end
        check(lng ? "R4 remainder" : "R3 remainder", {25'b0, rem_o}, {25'b0, exp});
        check("R5 done pulse", {31'b0, done_o}, 32'd1);
        check(chk ? "R6 mismatch" : "R7 mismatch off", {31'b0, mismatch_o},
              {31'b0, chk & corrupt});
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 done ends", {31'b0, done_o}, 32'd0);
        for (int k = 0; k < 3; k++) tick(1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 hold ignores bits", {25'b0, rem_o}, {25'b0, exp});
        for (int k = 0; k < 7; k++) begin
            check("R9 tx bit", {31'b0, tx_bit_o}, {31'b0, exp[6-k]});
            tick(1'b0, 1'b0, 1'b1, 1'b0);
        end
        check("R9 drained", {25'b0, rem_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [119:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset rem", {25'b0, rem_o}, 32'd0);
        check("R2 reset done", {30'b0, done_o, mismatch_o}, 32'd0);
        check("R9 reset tx", {31'b0, tx_bit_o}, 32'd0);

        // R1 known command value
        run_string(1'b0, {80'b0, 40'h40_0000_0000}, 1'b1, 1'b0, 1'b0);
        check("R1 known code", {25'b0, rem_o}, 32'd0);
        long_mode_i = 1'b0;
        for (int i = 39; i >= 0; i--) tick(1'b1, (i == 38), 1'b0, 1'b0);
        check("R1 known code 0x4A", {25'b0, rem_o}, 32'h4A);
        for (int k = 0; k < 7; k++) tick(1'b0, 1'b0, 1'b1, 1'b0);

        // R3 walking one over every short position
        for (int p = 0; p < 40; p++) begin
            m = '0; m[p] = 1'b1;
            run_string(1'b0, m, 1'b1, 1'b0, 1'b0);
        end
        // R3 R6 R7 pseudo-random short strings
        for (int v = 0; v < 24; v++) begin
            seed = nxt(seed); m = '0; m[31:0] = seed;
            seed = nxt(seed); m[39:32] = seed[7:0];
            run_string(1'b0, m, v[0], v[1], v[2]);
        end
        // R4 long strings with gaps
        for (int v = 0; v < 8; v++) begin
            for (int w = 0; w < 4; w++) begin
                seed = nxt(seed);
                m[w*32 +: 24] = seed[23:0];
                if (w < 3) m[w*32+24 +: 8] = seed[31:24];
            end
            run_string(1'b1, m, 1'b1, v[0], v[1]);
        end

        // R2 clear wins over a valid bit
        long_mode_i = 1'b0;
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b1, 1'b0, 1'b1);
        check("R2 clear rem", {25'b0, rem_o}, 32'd0);
        seed = nxt(seed); m = '0; m[31:0] = seed; m[39:32] = 8'hA5;
        run_string(1'b0, m, 1'b1, 1'b0, 1'b0);

        // R2 clear in hold state
        for (int i = 39; i >= 0; i--) tick(1'b1, 1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 clear from hold", {25'b0, rem_o}, 32'd0);
        run_string(1'b0, {80'b0, 40'h51_0000_0000}, 1'b1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule